// File: doc/BRIEF.md
# Shared-Buffer Multi-Queue Engine

The engine keeps 64 independent word queues in a single on-chip buffer made of 128 pages of 16 words each. Every queue has a packed configuration word that gives its starting page, its length (16, 32, 64 or 128 words) and two watermark codes. Once a queue has a configuration, a bus write to its access port appends one 32-bit entry and a bus read from that port removes the oldest entry. Each queue keeps its own read pointer, write pointer and fill count. The fill count drives the empty, nearly-empty, nearly-full and full status bits.

The block sits on a simple single-beat register bus with one operation per cycle. Bits 7:6 of the address select a region: the access ports, the configuration words, the fill-level status words, or the overflow flag words. Every read returns its data with a valid pulse one cycle after the request. Queues 0 to 31 have a sticky overflow flag. Queues 32 to 63 have none.

Top module: `shq_engine`

## Requirements
- R1: After reset every configuration word is zero, every queue is empty and every overflow flag is clear, so every read in every region returns the value that this state implies.
- R2: A bus write to address 0x40+q stores the configuration word of queue q, and a read at 0x40+q returns it. The word has these fields: page index at bits 21:14, size code at bits 25:24 (0..3 give 16, 32, 64 and 128 words), nearly-empty code at bits 28:26, and nearly-full code at bits 31:29.
- R3: A nonzero configuration write is discarded if its page index is below 4, or if its page index plus its page count is greater than 128. A write of zero is always accepted and makes the queue unassigned.
- R4: A write to address q (0..63) pushes an entry. A read at address q pops the oldest entry in first-in, first-out order. Every read raises rdValid, with rdata, exactly one cycle after the request.
- R5: A pop from an empty queue or an unassigned queue returns zero and does not change the queue's state.
- R6: A push to a full queue is dropped. For queues 0 to 31 it also sets the overflow flag, which reads at bit 2*(q mod 16) of the word at address 0xC0+(q/16). Odd bits always read zero. Queues 32 to 63 record no flag.
- R7: A write to an overflow word clears each flag whose bit in the written data is zero and keeps each flag whose bit is one. Writing zero clears all flags in that word.
- R8: The pointers wrap modulo the queue length. Entries stay inside the queue's own pages, so traffic on one queue never changes the data held in another queue.
- R9: An accepted configuration write empties the queue: its count and both pointers return to zero, and the entries it held are lost.
- R10: A read at 0x80+q returns the fill count in bits 7:6..0 (bits 7:0), empty at bit 8, nearly-empty (count <= T(ne)) at bit 9, nearly-full (free space <= T(nf)) at bit 10, and full at bit 11. The threshold is T(0)=0 and T(k)=2^(k-1) for k>0. All other bits read zero.
- R11: A push to an unassigned queue has no effect.
- R12: When busWr and busRd are both high in one cycle, only the write takes effect and no read response is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| busWr | input | 1 | Write strobe, one cycle |
| busRd | input | 1 | Read strobe, one cycle |
| busAddr | input | 8 | Word address; bits 7:6 select the region |
| busWdata | input | 32 | Write data |
| rdValid | output | 1 | Read response valid, one cycle after busRd |
| rdata | output | 32 | Read response data |

## Verification
The bench goes after the page-range limits on configuration writes (page 3, a range that ends exactly at page 128, and a range that runs past it). A design that got these wrong would place queue data on the reserved pages or outside the buffer. It fills queues to exactly their length and then pushes once more. A design with an off-by-one full test would overwrite the oldest entry, or would miss setting the flag, or would set a flag for an upper-half queue. It makes the pointers wrap many times while a neighbouring queue holds data, which exposes a missing wrap or a wrong base offset as corrupted entries in the neighbour. Pops from empty queues, reconfiguration of a queue that holds entries, and overlapping read and write strobes show whether stale data leaks out or whether a spurious response is raised.

// File: rtl/shq_pkg.sv
package shq_pkg;

  // Field positions inside a queue configuration word
  localparam int SizeLsb = 24;
  localparam int NeLsb   = 26;
  localparam int NfLsb   = 29;
  localparam int BaseLsb = 14;
  localparam int BaseW   = 8;

  typedef enum logic [1:0] {
    RGN_PORT = 2'd0,
    RGN_CFG  = 2'd1,
    RGN_LVL  = 2'd2,
    RGN_OVF  = 2'd3
  } region_e;

  typedef enum logic [1:0] {
    SRC_ZERO = 2'd0,
    SRC_CFG  = 2'd1,
    SRC_LVL  = 2'd2,
    SRC_OVF  = 2'd3
  } rdSrc_e;

  // Strobes from control to datapath, valid for the current cycle
  typedef struct packed {
    logic   push;
    logic   pop;
    logic   ovfSet;
    logic   cfgWr;
    logic   ovfWr;
    logic   respond;
    rdSrc_e src;
  } strobes_t;

  // Watermark code to entry threshold: 0 -> 0, k -> 2^(k-1)
  function automatic logic [7:0] wmThreshold(input logic [2:0] code);
    return (code == 3'd0) ? 8'd0 : (8'd1 << (code - 3'd1));
  endfunction

endpackage

// File: rtl/shq_ctrl.sv
module shq_ctrl
  import shq_pkg::*;
#(
  parameter int NUM_QUEUES = 64,
  parameter int PAGES      = 128,
  parameter int RSVD_PAGES = 4,
  parameter int DATA_W     = 32,
  parameter int OVF_WORDS  = 2,
  parameter int OW_W       = 1,
  localparam int QW        = $clog2(NUM_QUEUES),
  localparam int ADDR_W    = QW + 2
) (
  input  logic              busWr,
  input  logic              busRd,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  input  logic              selAssigned,
  input  logic              selFull,
  input  logic              selEmpty,
  output strobes_t          stb,
  output logic [QW-1:0]     qIdx,
  output logic [OW_W-1:0]   ovfSel
);

  region_e          region;
  logic             isWrite;
  logic             isRead;
  logic [BaseW-1:0] newBase;
  logic [BaseW:0]   newPages;
  logic [BaseW:0]   baseEnd;
  logic             cfgOk;
  logic             lowerHalf;
  logic             ovfInRange;

  assign region     = region_e'(busAddr[ADDR_W-1 -: 2]);
  assign qIdx       = busAddr[QW-1:0];
  assign ovfSel     = OW_W'(busAddr[QW-1:0]);
  assign isWrite    = busWr;
  assign isRead     = busRd && !busWr;
  assign lowerHalf  = !busAddr[QW-1];
  assign ovfInRange = int'(busAddr[QW-1:0]) < OVF_WORDS;

  // Placement check of a new configuration word
  assign newBase  = busWdata[BaseLsb +: BaseW];
  assign newPages = (BaseW+1)'(1) << busWdata[SizeLsb +: 2];
  assign baseEnd  = {1'b0, newBase} + newPages;
  assign cfgOk    = (busWdata == '0) ||
                    ((int'(newBase) >= RSVD_PAGES) && (int'(baseEnd) <= PAGES));

  always_comb begin
    stb         = '0;
    stb.src     = SRC_ZERO;
    stb.respond = isRead;
    unique case (region)
      RGN_PORT: begin
        stb.push   = isWrite && selAssigned && !selFull;
        stb.ovfSet = isWrite && selAssigned && selFull && lowerHalf;
        stb.pop    = isRead && selAssigned && !selEmpty;
        stb.src    = SRC_ZERO;
      end
      RGN_CFG: begin
        stb.cfgWr = isWrite && cfgOk;
        stb.src   = SRC_CFG;
      end
      RGN_LVL: begin
        stb.src = SRC_LVL;
      end
      RGN_OVF: begin
        stb.ovfWr = isWrite && ovfInRange;
        stb.src   = ovfInRange ? SRC_OVF : SRC_ZERO;
      end
      default: stb.src = SRC_ZERO;
    endcase
  end

endmodule

// File: rtl/shq_datapath.sv
module shq_datapath
  import shq_pkg::*;
#(
  parameter int NUM_QUEUES = 64,
  parameter int PAGES      = 128,
  parameter int PAGE_WORDS = 16,
  parameter int DATA_W     = 32,
  parameter int OVF_WORDS  = 2,
  parameter int OW_W       = 1,
  localparam int QW        = $clog2(NUM_QUEUES),
  localparam int HALF      = NUM_QUEUES / 2,
  localparam int MAX_LEN   = PAGE_WORDS * 8,
  localparam int PTR_W     = $clog2(MAX_LEN),
  localparam int CNT_W     = $clog2(MAX_LEN + 1),
  localparam int WORDS     = PAGES * PAGE_WORDS,
  localparam int WA_W      = $clog2(WORDS),
  localparam int PG_SH     = $clog2(PAGE_WORDS),
  localparam int OVF_PER_W = DATA_W / 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobes_t          stb,
  input  logic [QW-1:0]     qIdx,
  input  logic [OW_W-1:0]   ovfSel,
  input  logic [DATA_W-1:0] wdata,
  output logic              selAssigned,
  output logic              selFull,
  output logic              selEmpty,
  output logic              rdValid,
  output logic [DATA_W-1:0] rdata
);

  // Per-queue state
  logic [DATA_W-1:0] cfgQ  [NUM_QUEUES];
  logic [PTR_W-1:0]  rdPtr [NUM_QUEUES];
  logic [PTR_W-1:0]  wrPtr [NUM_QUEUES];
  logic [CNT_W-1:0]  cnt   [NUM_QUEUES];
  logic [HALF-1:0]   ovfFlags;

  // Shared buffer
  logic [DATA_W-1:0] mem [WORDS];
  logic [DATA_W-1:0] memQ;

  // Selected-queue view
  logic [DATA_W-1:0] selCfg;
  logic [1:0]        selSize;
  logic [BaseW-1:0]  selBase;
  logic [CNT_W-1:0]  selLen;
  logic [CNT_W-1:0]  selCnt;
  logic [PTR_W-1:0]  lenMask;
  logic [PTR_W-1:0]  nextWr;
  logic [PTR_W-1:0]  nextRd;
  logic [WA_W-1:0]   wrAddr;
  logic [WA_W-1:0]   rdAddr;
  logic              nearEmpty;
  logic              nearFull;
  logic [DATA_W-1:0] lvlWord;
  logic [DATA_W-1:0] ovfWord;
  logic [DATA_W-1:0] regSel;
  logic [DATA_W-1:0] regQ;
  logic              fromMem;

  assign selCfg      = cfgQ[qIdx];
  assign selSize     = selCfg[SizeLsb +: 2];
  assign selBase     = selCfg[BaseLsb +: BaseW];
  assign selLen      = CNT_W'(PAGE_WORDS) << selSize;
  assign selCnt      = cnt[qIdx];
  assign selAssigned = (selCfg != '0);
  assign selEmpty    = (selCnt == '0);
  assign selFull     = (selCnt == selLen);

  // Circular addressing inside the allotted pages
  assign lenMask = PTR_W'(selLen - 1'b1);
  assign nextWr  = PTR_W'(wrPtr[qIdx] + 1'b1) & lenMask;
  assign nextRd  = PTR_W'(rdPtr[qIdx] + 1'b1) & lenMask;
  assign wrAddr  = (WA_W'(selBase) << PG_SH) + WA_W'(wrPtr[qIdx]);
  assign rdAddr  = (WA_W'(selBase) << PG_SH) + WA_W'(rdPtr[qIdx]);

  for (genvar g = 0; g < NUM_QUEUES; g++) begin : gQueue
    logic hit;
    assign hit = (qIdx == QW'(g));
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        cfgQ[g]  <= '0;
        rdPtr[g] <= '0;
        wrPtr[g] <= '0;
        cnt[g]   <= '0;
      end else if (hit) begin
        if (stb.cfgWr) begin
          cfgQ[g]  <= wdata;
          rdPtr[g] <= '0;
          wrPtr[g] <= '0;
          cnt[g]   <= '0;
        end else if (stb.push) begin
          wrPtr[g] <= nextWr;
          cnt[g]   <= cnt[g] + 1'b1;
        end else if (stb.pop) begin
          rdPtr[g] <= nextRd;
          cnt[g]   <= cnt[g] - 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ovfFlags <= '0;
    end else if (stb.ovfSet) begin
      ovfFlags[qIdx[QW-2:0]] <= 1'b1;
    end else if (stb.ovfWr) begin
      for (int j = 0; j < OVF_PER_W; j++) begin
        ovfFlags[int'(ovfSel) * OVF_PER_W + j] <=
          ovfFlags[int'(ovfSel) * OVF_PER_W + j] & wdata[2*j];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (stb.push) mem[wrAddr] <= wdata;
    if (stb.pop)  memQ <= mem[rdAddr];
  end

  // Status words
  assign nearEmpty = (selCnt <= CNT_W'(wmThreshold(selCfg[NeLsb +: 3])));
  assign nearFull  = ((selLen - selCnt) <= CNT_W'(wmThreshold(selCfg[NfLsb +: 3])));
  assign lvlWord   = DATA_W'({selFull, nearFull, nearEmpty, selEmpty, selCnt});

  always_comb begin
    ovfWord = '0;
    for (int j = 0; j < OVF_PER_W; j++) begin
      ovfWord[2*j] = ovfFlags[int'(ovfSel) * OVF_PER_W + j];
    end
  end

  always_comb begin
    unique case (stb.src)
      SRC_CFG: regSel = selCfg;
      SRC_LVL: regSel = lvlWord;
      SRC_OVF: regSel = ovfWord;
      default: regSel = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdValid <= 1'b0;
      fromMem <= 1'b0;
      regQ    <= '0;
    end else begin
      rdValid <= stb.respond;
      fromMem <= stb.pop;
      if (stb.respond) regQ <= regSel;
    end
  end

  assign rdata = fromMem ? memQ : regQ;

endmodule

// File: rtl/shq_engine.sv
module shq_engine
  import shq_pkg::*;
#(
  parameter int NUM_QUEUES = 64,
  parameter int PAGES      = 128,
  parameter int PAGE_WORDS = 16,
  parameter int RSVD_PAGES = 4,
  parameter int DATA_W     = 32,
  localparam int ADDR_W    = $clog2(NUM_QUEUES) + 2,
  localparam int QW        = $clog2(NUM_QUEUES),
  localparam int OVF_WORDS = (NUM_QUEUES / 2) / (DATA_W / 2),
  localparam int OW_W      = (OVF_WORDS > 1) ? $clog2(OVF_WORDS) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWr,
  input  logic              busRd,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic              rdValid,
  output logic [DATA_W-1:0] rdata
);

  strobes_t        stb;
  logic [QW-1:0]   qIdx;
  logic [OW_W-1:0] ovfSel;
  logic            selAssigned;
  logic            selFull;
  logic            selEmpty;

  shq_ctrl #(
    .NUM_QUEUES(NUM_QUEUES),
    .PAGES     (PAGES),
    .RSVD_PAGES(RSVD_PAGES),
    .DATA_W    (DATA_W),
    .OVF_WORDS (OVF_WORDS),
    .OW_W      (OW_W)
  ) ctrl_i (
    .busWr      (busWr),
    .busRd      (busRd),
    .busAddr    (busAddr),
    .busWdata   (busWdata),
    .selAssigned(selAssigned),
    .selFull    (selFull),
    .selEmpty   (selEmpty),
    .stb        (stb),
    .qIdx       (qIdx),
    .ovfSel     (ovfSel)
  );

  shq_datapath #(
    .NUM_QUEUES(NUM_QUEUES),
    .PAGES     (PAGES),
    .PAGE_WORDS(PAGE_WORDS),
    .DATA_W    (DATA_W),
    .OVF_WORDS (OVF_WORDS),
    .OW_W      (OW_W)
  ) dp_i (
    .clk        (clk),
    .rstN       (rstN),
    .stb        (stb),
    .qIdx       (qIdx),
    .ovfSel     (ovfSel),
    .wdata      (busWdata),
    .selAssigned(selAssigned),
    .selFull    (selFull),
    .selEmpty   (selEmpty),
    .rdValid    (rdValid),
    .rdata      (rdata)
  );

endmodule

// File: rtl/shq_engine_chk.sv
module shq_engine_chk (
  input logic        clk,
  input logic        rstN,
  input logic        busWr,
  input logic        busRd,
  input logic [1:0]  rgn,
  input logic        rdValid,
  input logic [31:0] rdata
);

  logic [1:0] lastRgn;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) lastRgn <= 2'd0;
    else if (busRd && !busWr) lastRgn <= rgn;
  end

  AST_RESP_NEXT_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    (busRd && !busWr) |=> rdValid); // R4

  AST_WRITE_NO_RESP: assert property (@(posedge clk) disable iff (!rstN)
    busWr |=> !rdValid); // R12

  AST_IDLE_NO_RESP: assert property (@(posedge clk) disable iff (!rstN)
    !busRd |=> !rdValid); // R12

  AST_OVF_ODD_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (rdValid && lastRgn == 2'd3) |-> ((rdata & 32'hAAAA_AAAA) == 32'h0)); // R6

  AST_LVL_EMPTY_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    (rdValid && lastRgn == 2'd2) |-> (rdata[8] == (rdata[7:0] == 8'd0))); // R10

  AST_LVL_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (rdValid && lastRgn == 2'd2) |-> (rdata[31:12] == 20'd0)); // R10

  AST_LVL_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    (rdValid && lastRgn == 2'd2) |-> (rdata[7:0] <= 8'd128 && !(rdata[8] && rdata[11]))); // R8

endmodule

bind shq_engine shq_engine_chk chk_i (
  .clk    (clk),
  .rstN   (rstN),
  .busWr  (busWr),
  .busRd  (busRd),
  .rgn    (busAddr[ADDR_W-1 -: 2]),
  .rdValid(rdValid),
  .rdata  (rdata)
);

// File: tb/shq_engine_tb.sv
`timescale 1ns/1ps
module shq_engine_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busWr = 1'b0;
  logic        busRd = 1'b0;
  logic [7:0]  busAddr = '0;
  logic [31:0] busWdata = '0;
  logic        rdValid;
  logic [31:0] rdata;

  int    checks = 0;
  int    fails = 0;
  bit    done = 1'b0;
  string phaseTag = "R1";

  always #10 clk = ~clk; // 50 MHz

  shq_engine dut_i (
    .clk(clk), .rstN(rstN), .busWr(busWr), .busRd(busRd),
    .busAddr(busAddr), .busWdata(busWdata), .rdValid(rdValid), .rdata(rdata)
  );

  // ---------------- behavioural reference model ----------------
  int unsigned refCfg [64];
  int unsigned refQ   [64][$];
  bit          refOvf [32];
  bit          expValid = 1'b0;
  logic [31:0] expData = '0;

  function automatic int unsigned lenOf(int unsigned c);
    return 16 << ((c >> 24) & 3);
  endfunction

  function automatic int unsigned thr(int unsigned code);
    return (code == 0) ? 0 : (1 << (code - 1));
  endfunction

  function automatic bit cfgAccepted(int unsigned w);
    int unsigned base = (w >> 14) & 255;
    int unsigned pages = 1 << ((w >> 24) & 3);
    return (w == 0) || (base >= 4 && base + pages <= 128);
  endfunction

  function automatic int unsigned mkCfg(int unsigned base, int unsigned sz,
                                        int unsigned ne, int unsigned nf);
    return (nf << 29) | (ne << 26) | (sz << 24) | (base << 14);
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < 64; i++) begin
        refCfg[i] = 0;
        refQ[i].delete();
      end
      for (int i = 0; i < 32; i++) refOvf[i] = 1'b0;
      expValid <= 1'b0;
      expData  <= '0;
    end else begin
      automatic int rg = int'(busAddr[7:6]);
      automatic int q = int'(busAddr[5:0]);
      automatic int unsigned d = 0;
      if (busWr) begin
        case (rg)
          0: if (refCfg[q] != 0) begin
               if (refQ[q].size() == lenOf(refCfg[q])) begin
                 if (q < 32) refOvf[q] = 1'b1;
               end else refQ[q].push_back(busWdata);
             end
          1: if (cfgAccepted(busWdata)) begin
               refCfg[q] = busWdata;
               refQ[q].delete();
             end
          3: if (q < 2)
               for (int j = 0; j < 16; j++)
                 refOvf[q*16+j] = refOvf[q*16+j] & busWdata[2*j];
          default: ;
        endcase
      end else if (busRd) begin
        case (rg)
          0: if (refCfg[q] != 0 && refQ[q].size() > 0) d = refQ[q].pop_front();
          1: d = refCfg[q];
          2: begin
               automatic int unsigned c = refQ[q].size();
               automatic int unsigned l = lenOf(refCfg[q]);
               d = c;
               if (c == 0) d |= 32'h100;
               if (c <= thr((refCfg[q] >> 26) & 7)) d |= 32'h200;
               if ((l - c) <= thr((refCfg[q] >> 29) & 7)) d |= 32'h400;
               if (c == l) d |= 32'h800;
             end
          default: if (q < 2)
               for (int j = 0; j < 16; j++) if (refOvf[q*16+j]) d |= (1 << (2*j));
        endcase
      end
      expValid <= busRd && !busWr;
      expData  <= d;
    end
  end

  // ---------------- per-clock comparison ----------------
  task automatic check(bit ok, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", phaseTag, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rstN && !done) begin
      check(rdValid == expValid, "rdValid", 32'(rdValid), 32'(expValid));
      if (expValid) check(rdata == expData, "rdata", rdata, expData);
    end
  end

  // ---------------- stimulus tasks ----------------
  task automatic wr(int a, int unsigned d);
    @(negedge clk);
    busWr = 1'b1; busRd = 1'b0; busAddr = 8'(a); busWdata = d;
  endtask

  task automatic rd(int a);
    @(negedge clk);
    busWr = 1'b0; busRd = 1'b1; busAddr = 8'(a); busWdata = '0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      busWr = 1'b0; busRd = 1'b0;
    end
  endtask

  // ---------------- scenarios ----------------
  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    idle(2);

    phaseTag = "R1"; // reset state visible in all regions
    rd(8'h40); rd(8'h85); rd(8'hC0); rd(8'hC1); rd(8'h03);
    idle(1);

    phaseTag = "R11"; // push to unassigned queue ignored
    wr(8'h07, 32'h1234); rd(8'h87); rd(8'h07);
    idle(1);

    phaseTag = "R2"; // config decode and readback
    wr(8'h40, mkCfg(4, 0, 1, 2)); rd(8'h40);
    wr(8'h68, mkCfg(5, 1, 0, 3)); rd(8'h68);
    wr(8'h51, mkCfg(8, 0, 0, 0)); rd(8'h51);
    idle(1);

    phaseTag = "R3"; // placement limits
    wr(8'h41, mkCfg(3, 0, 0, 0)); rd(8'h41);
    wr(8'h42, mkCfg(125, 2, 0, 0)); rd(8'h42);
    wr(8'h42, mkCfg(124, 2, 0, 0)); rd(8'h42);
    wr(8'h42, 0); rd(8'h42);
    idle(1);

    phaseTag = "R4"; // FIFO order and response timing
    wr(8'h00, 32'hA0000001); wr(8'h00, 32'hA0000002); wr(8'h00, 32'hA0000003);
    rd(8'h00); rd(8'h00); rd(8'h00);
    idle(1);

    phaseTag = "R5"; // pop from empty queue
    rd(8'h00); rd(8'h80); rd(8'h00);
    idle(1);

    phaseTag = "R6"; // overflow on full queues
    for (int i = 0; i < 17; i++) wr(8'h00, 32'hB000_0000 + i);
    rd(8'hC0); rd(8'h80);
    for (int i = 0; i < 17; i++) wr(8'h11, 32'hC000_0000 + i);
    rd(8'hC1);
    for (int i = 0; i < 33; i++) wr(8'h28, 32'hD000_0000 + i);
    rd(8'hC0); rd(8'hC1); rd(8'hA8);
    idle(1);

    phaseTag = "R7"; // overflow clear by write
    wr(8'hC0, 32'hFFFF_FFFF); rd(8'hC0);
    wr(8'hC1, 32'hFFFF_FFFB); rd(8'hC1);
    wr(8'hC0, 32'h0); rd(8'hC0);
    idle(1);

    phaseTag = "R8"; // wrap and neighbour integrity
    for (int i = 0; i < 8; i++) rd(8'h00);
    for (int i = 0; i < 40; i++) begin
      wr(8'h00, 32'hE000_0000 + i);
      rd(8'h00);
    end
    for (int i = 0; i < 33; i++) rd(8'h28);
    rd(8'hA8);
    idle(1);

    phaseTag = "R9"; // reconfiguration empties the queue
    rd(8'h80);
    wr(8'h40, mkCfg(4, 0, 1, 2)); rd(8'h80); rd(8'h00);
    idle(1);

    phaseTag = "R10"; // level word and watermarks
    rd(8'h80);
    for (int i = 0; i < 16; i++) begin
      wr(8'h00, 32'hF000_0000 + i);
      rd(8'h80);
    end
    for (int i = 0; i < 16; i++) begin
      rd(8'h00);
      rd(8'h80);
    end
    idle(1);

    phaseTag = "R12"; // overlapping strobes
    @(negedge clk);
    busWr = 1'b1; busRd = 1'b1; busAddr = 8'h00; busWdata = 32'h5A5A_0001;
    @(negedge clk);
    busWr = 1'b1; busRd = 1'b1; busAddr = 8'h80; busWdata = 32'h0;
    rd(8'h80); rd(8'h00);
    idle(1);

    phaseTag = "R8"; // mixed traffic on several queues
    for (int i = 0; i < 3000; i++) begin
      automatic int unsigned r = $urandom;
      automatic int qsel = (r[1:0] == 0) ? 0 : (r[1:0] == 1) ? 17 : (r[1:0] == 2) ? 40 : 2;
      case (r[4:2])
        0, 1, 2: wr(qsel, r);
        3, 4, 5: rd(qsel);
        6:       rd(8'h80 + qsel);
        default: rd(8'hC0 + int'(r[5]));
      endcase
    end
    idle(3);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      fails++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule